// File: doc/BRIEF.md
# One-Time-Programmable Region Guard

This block holds a 1024-byte one-time-programmable space in registers and decides, for every byte-wide program request from the host, whether the write may land. The space is cut into 32 aligned regions of 32 bytes each. A request is refused in any of three cases: it targets the 16-byte factory key at the bottom of region 0, the region it falls in has been locked, or the global freeze input is high. Programming is one-way. Erased bytes read as all ones, and a program can only clear bits.

The lock state is kept inside the protected space itself. Bytes 16 to 19 form a 32-bit word, and bit n of that word guards region n. A lock bit at 0 means its region is locked. Byte 16 holds bits 0 to 7, byte 17 holds bits 8 to 15, and so on. Region 0 contains the lock word, so locking region 0 also freezes the lock state of every region.

A factory load port writes the 16 key bytes in one cycle. It works only once, and only before the host has issued any request. Reads return a byte one cycle later, whatever the lock or freeze state.

Top module: `otp_guard`

## Requirements
- R1: After reset every byte reads 0xFF, and done_o and rd_valid_o are low.
- R2: An accepted program stores the old byte AND wdata_i, so no bit ever returns from 0 to 1.
- R3: A host program to addresses 0 to 15 is always rejected and leaves the byte unchanged.
- R4: Bit n of the lock word {byte19, byte18, byte17, byte16} guards region addr[9:5] == n. While that bit is 0, every program to the region is rejected and the region is unchanged. Other regions stay programmable.
- R5: Bytes 20 to 31 accept host programs while lock bit 0 is 1. Once lock bit 0 is 0, programs to bytes 16 to 31 are rejected, including the lock word itself.
- R6: While freeze_i is 1, every program is rejected. Reads still return the stored byte.
- R7: Each program request sampled on an edge gives done_o high for exactly the following cycle. accepted_o in that cycle shows whether the byte was written. With no request, both are low.
- R8: A read request sampled on an edge gives rd_valid_o in the next cycle, with rdata_o equal to the byte as it stood before any write on that same edge.
- R9: fact_load_i writes byte i from fact_key_i[8i+7:8i] for i = 0 to 15. It has an effect only if no load has happened yet and no program or read request has been seen since reset, including one in the same cycle. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze_i | input | 1 | Global program inhibit |
| fact_load_i | input | 1 | Factory key load strobe |
| fact_key_i | input | 128 | Factory key, byte i in bits 8i+7:8i |
| pgm_req_i | input | 1 | Program request |
| rd_req_i | input | 1 | Read request |
| addr_i | input | 10 | Byte address shared by program and read |
| wdata_i | input | 8 | Program data, ANDed into the byte |
| done_o | output | 1 | Program completion pulse |
| accepted_o | output | 1 | Program was written (valid with done_o) |
| rd_valid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data |

## Verification
The protection decision depends on state inside the array, so a corrupted byte shows up in one of two ways. If the byte is read, rdata_o is wrong one cycle after the read. If the byte is part of the lock word, the error appears one cycle after the next program to the affected region, as a wrong accepted_o. A stale host-access or load flag shows up as a key that was or was not replaced, and the next read of bytes 0 to 15 exposes it. The bench drives directed scenarios and a long mixed sequence, and compares every output on every cycle against a behavioural byte-array model.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic key_hit;
    logic lockw_hit;
  } otp_zone_t;

  function automatic logic [BYTE_W-1:0] otp_burn(input logic [BYTE_W-1:0] cur,
                                                input logic [BYTE_W-1:0] val);
    return cur & val;
  endfunction
endpackage

// File: rtl/otp_addr_dec.sv
module otp_addr_dec #(
  parameter int unsigned AW         = 10,
  parameter int unsigned RW         = 5,
  parameter int unsigned KEY_BYTES  = 16,
  parameter int unsigned LOCK_BASE  = 16,
  parameter int unsigned LOCK_BYTES = 4
) (
  input  logic [AW-1:0]       addr,
  output logic [RW-1:0]       region,
  output otp_pkg::otp_zone_t  zone
);
  localparam int unsigned OFS_W = AW - RW;

  always_comb begin
    region         = addr[AW-1:OFS_W];
    zone.key_hit   = (addr < AW'(KEY_BYTES));
    zone.lockw_hit = (addr >= AW'(LOCK_BASE)) && (addr < AW'(LOCK_BASE + LOCK_BYTES));
  end
endmodule

// File: rtl/otp_prot_eval.sv
module otp_prot_eval #(
  parameter int unsigned NREG = 32,
  parameter int unsigned RW   = 5
) (
  input  logic               pgm_req,
  input  logic               freeze,
  input  logic [NREG-1:0]    open_vec,
  input  logic [RW-1:0]      region,
  input  otp_pkg::otp_zone_t zone,
  output logic               grant
);
  logic region_open;

  always_comb begin
    region_open = open_vec[region];
    grant       = pgm_req && !freeze && !zone.key_hit && region_open;
  end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int unsigned BYTES     = 1024,
  parameter int unsigned AW        = 10,
  parameter int unsigned KEY_BYTES = 16,
  parameter int unsigned LOCK_BASE = 16,
  parameter int unsigned NREG      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     ld_en,
  input  logic [KEY_BYTES*8-1:0]   ld_key,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [7:0]               rd_data,
  output logic [NREG-1:0]          open_vec
);
  logic [7:0] mem_q [BYTES];
  logic [7:0] mem_d [BYTES];
  logic       mem_en [BYTES];
  logic [7:0] rd_d;

  for (genvar g = 0; g < BYTES; g++) begin : g_byte
    if (g < KEY_BYTES) begin : g_key
      always_comb begin
        mem_en[g] = ld_en;
        mem_d[g]  = ld_key[8*g +: 8];
      end
    end else begin : g_host
      always_comb begin
        mem_en[g] = wr_en && (wr_addr == AW'(g));
        mem_d[g]  = otp_pkg::otp_burn(mem_q[g], wr_data);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mem_q[g] <= 8'hFF;
      else if (mem_en[g])  mem_q[g] <= mem_d[g];
    end
  end

  for (genvar n = 0; n < NREG; n++) begin : g_lock
    assign open_vec[n] = mem_q[LOCK_BASE + n/8][n%8];
  end

  always_comb rd_d = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'hFF;
    else if (rd_en) rd_data <= rd_d;
  end
endmodule

// File: rtl/otp_guard.sv
module otp_guard #(
  parameter int unsigned BYTES        = 1024,
  parameter int unsigned REGION_BYTES = 32,
  parameter int unsigned KEY_BYTES    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      freeze_i,
  input  logic                      fact_load_i,
  input  logic [KEY_BYTES*8-1:0]    fact_key_i,
  input  logic                      pgm_req_i,
  input  logic                      rd_req_i,
  input  logic [$clog2(BYTES)-1:0]  addr_i,
  input  logic [7:0]                wdata_i,
  output logic                      done_o,
  output logic                      accepted_o,
  output logic                      rd_valid_o,
  output logic [7:0]                rdata_o
);
  localparam int unsigned AW         = $clog2(BYTES);
  localparam int unsigned NREG       = BYTES / REGION_BYTES;
  localparam int unsigned RW         = $clog2(NREG);
  localparam int unsigned LOCK_BASE  = KEY_BYTES;
  localparam int unsigned LOCK_BYTES = NREG / 8;

  logic [RW-1:0]      region;
  otp_pkg::otp_zone_t zone;
  logic [NREG-1:0]    open_vec;
  logic               grant;
  logic               ld_ok;

  logic touched_q, touched_d;
  logic loaded_q,  loaded_d;
  logic done_d, acc_d, rv_d;

  otp_addr_dec #(.AW(AW), .RW(RW), .KEY_BYTES(KEY_BYTES),
                 .LOCK_BASE(LOCK_BASE), .LOCK_BYTES(LOCK_BYTES)) u_dec (
    .addr(addr_i), .region(region), .zone(zone));

  otp_prot_eval #(.NREG(NREG), .RW(RW)) u_eval (
    .pgm_req(pgm_req_i), .freeze(freeze_i), .open_vec(open_vec),
    .region(region), .zone(zone), .grant(grant));

  otp_store #(.BYTES(BYTES), .AW(AW), .KEY_BYTES(KEY_BYTES),
              .LOCK_BASE(LOCK_BASE), .NREG(NREG)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(grant), .wr_addr(addr_i), .wr_data(wdata_i),
    .ld_en(ld_ok), .ld_key(fact_key_i),
    .rd_en(rd_req_i), .rd_addr(addr_i), .rd_data(rdata_o),
    .open_vec(open_vec));

  always_comb begin
    ld_ok     = fact_load_i && !touched_q && !loaded_q && !pgm_req_i && !rd_req_i;
    touched_d = touched_q || pgm_req_i || rd_req_i;
    loaded_d  = loaded_q || ld_ok;
    done_d    = pgm_req_i;
    acc_d     = grant;
    rv_d      = rd_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched_q  <= 1'b0;
      loaded_q   <= 1'b0;
      done_o     <= 1'b0;
      accepted_o <= 1'b0;
      rd_valid_o <= 1'b0;
    end else begin
      touched_q  <= touched_d;
      loaded_q   <= loaded_d;
      done_o     <= done_d;
      accepted_o <= acc_d;
      rd_valid_o <= rv_d;
    end
  end
endmodule

// File: rtl/otp_guard_chk.sv
module otp_guard_chk #(
  parameter int unsigned AW   = 10,
  parameter int unsigned NREG = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            freeze_i,
  input logic            pgm_req_i,
  input logic            rd_req_i,
  input logic [AW-1:0]   addr_i,
  input logic            done_o,
  input logic            accepted_o,
  input logic            rd_valid_o,
  input logic [NREG-1:0] open_vec
);
  localparam int unsigned RW = $clog2(NREG);

  p_done_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req_i |=> done_o);
  p_no_spurious_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_req_i |=> (!done_o && !accepted_o));
  p_freeze_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req_i && freeze_i) |=> !accepted_o);
  p_key_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req_i && addr_i < AW'(16)) |=> !accepted_o);
  p_locked_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req_i && !open_vec[addr_i[AW-1:AW-RW]]) |=> !accepted_o);
  p_lock_one_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((open_vec & ~$past(open_vec)) == '0));
  p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_valid_o);
  p_no_spurious_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_valid_o);
endmodule

bind otp_guard otp_guard_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .pgm_req_i(pgm_req_i),
  .rd_req_i(rd_req_i), .addr_i(addr_i), .done_o(done_o),
  .accepted_o(accepted_o), .rd_valid_o(rd_valid_o), .open_vec(open_vec));

// File: tb/otp_guard_test.sv
module otp_guard_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         freeze_i = 1'b0;
  logic         fact_load_i = 1'b0;
  logic [127:0] fact_key_i = '0;
  logic         pgm_req_i = 1'b0;
  logic         rd_req_i = 1'b0;
  logic [9:0]   addr_i = '0;
  logic [7:0]   wdata_i = '0;
  logic         done_o, accepted_o, rd_valid_o;
  logic [7:0]   rdata_o;

  otp_guard uut (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .fact_load_i(fact_load_i),
    .fact_key_i(fact_key_i), .pgm_req_i(pgm_req_i), .rd_req_i(rd_req_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .done_o(done_o), .accepted_o(accepted_o),
    .rd_valid_o(rd_valid_o), .rdata_o(rdata_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int     m_mem [1024];
  bit     m_touched, m_loaded;
  bit     e_done, e_acc, e_rv;
  int     e_rd;
  int     n_chk = 0, n_bad = 0;
  string  cur_req = "R1";
  bit     finished = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) m_mem[i] = 255;
      m_touched = 0; m_loaded = 0;
      e_done = 0; e_acc = 0; e_rv = 0; e_rd = 255;
    end else begin
      int a;
      int lockbit;
      bit ok;
      a = int'(addr_i);
      lockbit = (m_mem[16 + (a/32)/8] >> ((a/32)%8)) & 1;
      ok = pgm_req_i && !freeze_i && (a >= 16) && (lockbit == 1);
      e_done = pgm_req_i;
      e_acc  = ok;
      e_rv   = rd_req_i;
      if (rd_req_i) e_rd = m_mem[a];
      if (fact_load_i && !m_touched && !m_loaded && !pgm_req_i && !rd_req_i) begin
        for (int i = 0; i < 16; i++) m_mem[i] = int'(fact_key_i[8*i +: 8]);
        m_loaded = 1;
      end
      if (ok) m_mem[a] = m_mem[a] & int'(wdata_i);
      if (pgm_req_i || rd_req_i) m_touched = 1;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("done", int'(done_o), int'(e_done));
      chk("accepted", int'(accepted_o), int'(e_acc));
      chk("rd_valid", int'(rd_valid_o), int'(e_rv));
      if (rd_valid_o) chk("rdata", int'(rdata_o), e_rd);
    end
  end

  task automatic step(input bit p, input bit r, input int a, input int d);
    @(negedge clk);
    pgm_req_i = p; rd_req_i = r; addr_i = 10'(a); wdata_i = 8'(d);
    @(negedge clk);
    pgm_req_i = 0; rd_req_i = 0;
  endtask

  task automatic pgm(input int a, input int d); step(1, 0, a, d); endtask
  task automatic rd(input int a);               step(0, 1, a, 0); endtask

  task automatic fload(input logic [127:0] k);
    @(negedge clk);
    fact_key_i = k; fact_load_i = 1;
    @(negedge clk);
    fact_load_i = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset contents
    cur_req = "R1";
    @(negedge clk);
    chk("reset done", int'(done_o), 0);
    chk("reset rv", int'(rd_valid_o), 0);
    rd(0); rd(16); rd(517); rd(1023);
    // R9 load after host access ignored
    cur_req = "R9";
    fload(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
    rd(0); rd(15);
    do_reset();
    cur_req = "R9";
    fload(128'hA5A5_0F0F_1234_5678_9ABC_DEF0_5A5A_C3C3);
    fload(128'h0);
    for (int i = 0; i < 16; i++) rd(i);
    // R3 key protected
    cur_req = "R3";
    pgm(0, 8'h00); pgm(7, 8'h00); pgm(15, 8'h00); rd(0); rd(7); rd(15);
    // R2 AND programming
    cur_req = "R2";
    pgm(100, 8'hF0); pgm(100, 8'h3C); pgm(100, 8'hFF); rd(100);
    // R5 reserved bytes while unlocked
    cur_req = "R5";
    pgm(25, 8'h00); rd(25); pgm(31, 8'h5A); rd(31);
    // R4 lock region 3 via byte 16 bit 3
    cur_req = "R4";
    pgm(16, 8'hF7); rd(16);
    pgm(96, 8'h00); pgm(127, 8'h00); rd(96); rd(127);
    pgm(128, 8'h0F); rd(128); pgm(95, 8'h11); rd(95);
    // R4 lock region 30 via byte 19 bit 6
    pgm(19, 8'hBF); pgm(980, 8'h00); rd(980);
    // R6 freeze
    cur_req = "R6";
    freeze_i = 1;
    pgm(200, 8'h00); pgm(16, 8'h00); rd(200); rd(0);
    freeze_i = 0;
    pgm(200, 8'h0F); rd(200);
    // R7 read and program in one cycle, R8 read sees old value
    cur_req = "R8";
    step(1, 1, 300, 8'h00); rd(300);
    cur_req = "R7";
    step(1, 1, 5, 8'h00);
    // R5 lock region 0 freezes lock word
    cur_req = "R5";
    pgm(16, 8'hFE); pgm(17, 8'h00); pgm(24, 8'h00); pgm(19, 8'h00);
    rd(16); rd(17); rd(24); rd(19);
    pgm(500, 8'h77); rd(500);
    // mixed traffic
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      bit p, r;
      int a;
      p = ($urandom % 3) != 0;
      r = ($urandom % 2) != 0;
      a = ($urandom % 4 == 0) ? int'($urandom % 40) : int'($urandom % 1024);
      freeze_i = ($urandom % 8) == 0;
      step(p, r, a, int'($urandom % 256));
    end
    freeze_i = 0;
    // R1 again after a fresh reset
    do_reset();
    cur_req = "R1";
    rd(16); rd(100); rd(0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule